// File: doc/BRIEF.md
# Demand-Gated Cascaded Clock-Enable Divider

This block turns one fast clock into a family of single-cycle clock-enable pulses. All of them live in the fast clock's domain, so no derived clock ever drives a flop's clock pin. A bus enable runs at 1/1, 1/2 or 1/3 of the fast clock, as set by a configuration register. An interrupt-timing enable runs at one quarter of the bus rate, and a free-running tick counter advances once per interrupt-timing period.

Three further enables are demand-gated. A memory enable runs at the bus rate. A peripheral enable is divided down from the bus enable. An external-bus enable is divided down again from the peripheral enable. Each gated enable runs only while its request input is high. It starts on the next pulse of its parent and always finishes the period it has started, so no shortened period is ever seen.

Divider settings are loaded into internal configuration registers by a write strobe. A loaded setting takes effect only at the next period boundary of the divider it controls.

Top module: `clkdiv_tree`

## Requirements
- R1: `cfg_bus_code` value 0, 1, 2 or 3 makes `bus_en` pulse once every 1, 2, 3 or 3 fast-clock cycles.
- R2: While `rst` is high and after it, every enable and run output is 0 and `tick_count` is 0. The configuration registers return to bus code 1, peripheral code 1 and external code 1, each a ratio of 2.
- R3: `irq_en` pulses once every 4 `bus_en` pulses, and only in the cycle after a `bus_en` pulse.
- R4: `tick_count` rises by one in the cycle after each `irq_en` pulse and holds otherwise.
- R5: `tick_count` wraps from all ones to zero.
- R6: While `req_mem` is high, `mem_en` pulses in the cycle after every `bus_en` pulse. With `req_mem` low, `mem_en` stops and `mem_run` is 0.
- R7: Peripheral code c (0 to 3) gives one `prph_en` pulse per 2^c `bus_en` pulses.
- R8: External code c (0 to 3) gives one `xbus_en` pulse per 2^c `prph_en` pulses.
- R9: An idle gated enable starts when its request is high at a parent pulse. Its first pulse appears in the cycle after that parent pulse.
- R10: After its request falls, a gated enable gives no further pulse. Its run output stays 1 until the period in progress is complete, then falls to 0.
- R11: A setting written with `cfg_wr` while a divider runs leaves the current period at the old ratio. The new ratio applies from the next period boundary.
- R12: `req_xbus` high keeps the peripheral divider running even with `req_prph` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Loads the three code inputs into the configuration registers |
| cfg_bus_code | input | 2 | Bus ratio code (0: 1/1, 1: 1/2, 2 and 3: 1/3) |
| cfg_prph_code | input | DIV_SEL_W | Peripheral divide code, ratio 2^code |
| cfg_xbus_code | input | DIV_SEL_W | External-bus divide code, ratio 2^code |
| req_mem | input | 1 | Memory access in progress |
| req_prph | input | 1 | Peripheral-bus access in progress |
| req_xbus | input | 1 | External-bus access in progress |
| bus_en | output | 1 | Bus-rate enable pulse |
| irq_en | output | 1 | Quarter-bus-rate interrupt-timing pulse |
| mem_en | output | 1 | Gated memory enable pulse |
| mem_run | output | 1 | Memory enable period in progress |
| prph_en | output | 1 | Gated peripheral enable pulse |
| prph_run | output | 1 | Peripheral enable period in progress |
| xbus_en | output | 1 | Gated external-bus enable pulse |
| xbus_run | output | 1 | External-bus enable period in progress |
| tick_count | output | CNT_W | Free-running tick counter |

## Verification
Several properties are checked on every cycle. A divider's count never passes its active ratio, and a ratio changes only on a parent pulse. A run flag falls only on a parent pulse with the request low. Every derived pulse follows a parent pulse, and the tick counter steps or holds exactly as required. The bench scenarios alone show the actual period lengths for each code, the exact cycle a gated enable starts, the old ratio being kept until the boundary after a write, the cascade being kept alive by the external request, and the counter wrap.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int BUS_SEL_W = 2;
  localparam int BUS_CW    = 2;
  localparam int IRQ_DIV   = 4;
  localparam int IRQ_CW    = $clog2(IRQ_DIV);

  localparam logic [BUS_SEL_W-1:0] BUS_RST_CODE = 2'd1;

  // bus code -> ratio minus one; codes above 2 fold onto 1/3
  function automatic logic [BUS_CW-1:0] bus_m1(input logic [BUS_SEL_W-1:0] code);
    case (code)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/bus_div.sv
module bus_div #(
  parameter int CW = 2,
  parameter logic [CW-1:0] RST_M1 = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] ratio_m1,
  output logic          en_q
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] ratio_act;
  logic          at_end;

  assign at_end = (cnt == ratio_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      ratio_act <= RST_M1;
      en_q      <= 1'b0;
    end else begin
      en_q <= at_end;
      if (at_end) begin
        cnt       <= '0;
        ratio_act <= ratio_m1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
    cnt <= ratio_act);

  assert_ratio_at_end_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(ratio_act) |-> $past(at_end));
endmodule

// File: rtl/gated_div.sv
module gated_div #(
  parameter int CW = 3,
  parameter logic [CW-1:0] RST_M1 = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          par_en,
  input  logic          req,
  input  logic [CW-1:0] ratio_m1,
  output logic          en_q,
  output logic          run_q
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] ratio_act;
  logic          boundary;
  logic          emit;

  always_comb begin
    boundary = par_en && (!run_q || (cnt == ratio_act));
    emit     = boundary && req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      ratio_act <= RST_M1;
      run_q     <= 1'b0;
      en_q      <= 1'b0;
    end else begin
      en_q <= emit;
      if (boundary) begin
        cnt <= '0;
        if (req) begin
          run_q     <= 1'b1;
          ratio_act <= ratio_m1;
        end else begin
          run_q <= 1'b0;
        end
      end else if (par_en) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_pulse_in_run_R9: assert property (@(posedge clk) disable iff (rst)
    en_q |-> run_q);

  assert_pulse_after_parent_R9: assert property (@(posedge clk) disable iff (rst)
    en_q |-> $past(par_en));

  assert_stop_full_period_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> ($past(par_en) && !$past(req)));

  assert_ratio_at_boundary_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(ratio_act) |-> $past(par_en));

  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt <= ratio_act));
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    inc |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(cnt_q));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (inc && (cnt_q == '1)) |=> (cnt_q == '0));
endmodule

// File: rtl/clkdiv_tree.sv
module clkdiv_tree
  import clkdiv_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int DIV_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr,
  input  logic [1:0]           cfg_bus_code,
  input  logic [DIV_SEL_W-1:0] cfg_prph_code,
  input  logic [DIV_SEL_W-1:0] cfg_xbus_code,
  input  logic                 req_mem,
  input  logic                 req_prph,
  input  logic                 req_xbus,
  output logic                 bus_en,
  output logic                 irq_en,
  output logic                 mem_en,
  output logic                 mem_run,
  output logic                 prph_en,
  output logic                 prph_run,
  output logic                 xbus_en,
  output logic                 xbus_run,
  output logic [CNT_W-1:0]     tick_count
);
  localparam int PDIV_CW = (1 << DIV_SEL_W) - 1;
  localparam logic [DIV_SEL_W-1:0] DIV_RST_CODE = DIV_SEL_W'(1);
  localparam logic [PDIV_CW-1:0]   DIV_RST_M1   = PDIV_CW'(1);
  localparam logic [IRQ_CW-1:0]    IRQ_M1       = IRQ_CW'(IRQ_DIV - 1);

  // code c -> 2^c - 1 as a thermometer value
  function automatic logic [PDIV_CW-1:0] div_m1(input logic [DIV_SEL_W-1:0] code);
    logic [PDIV_CW-1:0] r;
    r = '0;
    for (int i = 0; i < PDIV_CW; i++) r[i] = (i < int'(code));
    return r;
  endfunction

  logic [1:0]           bus_code_q;
  logic [DIV_SEL_W-1:0] prph_code_q;
  logic [DIV_SEL_W-1:0] xbus_code_q;
  logic                 irq_run;
  logic                 prph_req_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_code_q  <= BUS_RST_CODE;
      prph_code_q <= DIV_RST_CODE;
      xbus_code_q <= DIV_RST_CODE;
    end else if (cfg_wr) begin
      bus_code_q  <= cfg_bus_code;
      prph_code_q <= cfg_prph_code;
      xbus_code_q <= cfg_xbus_code;
    end
  end

  assign prph_req_any = req_prph | req_xbus;

  bus_div #(.CW(BUS_CW), .RST_M1(bus_m1(BUS_RST_CODE))) u_bus (
    .clk(clk), .rst(rst), .ratio_m1(bus_m1(bus_code_q)), .en_q(bus_en));

  gated_div #(.CW(IRQ_CW), .RST_M1(IRQ_M1)) u_irq (
    .clk(clk), .rst(rst), .par_en(bus_en), .req(1'b1), .ratio_m1(IRQ_M1),
    .en_q(irq_en), .run_q(irq_run));

  gated_div #(.CW(1), .RST_M1(1'b0)) u_mem (
    .clk(clk), .rst(rst), .par_en(bus_en), .req(req_mem), .ratio_m1(1'b0),
    .en_q(mem_en), .run_q(mem_run));

  gated_div #(.CW(PDIV_CW), .RST_M1(DIV_RST_M1)) u_prph (
    .clk(clk), .rst(rst), .par_en(bus_en), .req(prph_req_any),
    .ratio_m1(div_m1(prph_code_q)), .en_q(prph_en), .run_q(prph_run));

  gated_div #(.CW(PDIV_CW), .RST_M1(DIV_RST_M1)) u_xbus (
    .clk(clk), .rst(rst), .par_en(prph_en), .req(req_xbus),
    .ratio_m1(div_m1(xbus_code_q)), .en_q(xbus_en), .run_q(xbus_run));

  tick_counter #(.W(CNT_W)) u_tick (
    .clk(clk), .rst(rst), .inc(irq_en), .cnt_q(tick_count));

  assert_irq_follows_bus_R3: assert property (@(posedge clk) disable iff (rst)
    irq_en |-> $past(bus_en));

  assert_irq_always_runs_R3: assert property (@(posedge clk) disable iff (rst)
    bus_en |=> irq_run);

  assert_mem_follows_bus_R6: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> $past(bus_en));

  assert_xbus_in_prph_R12: assert property (@(posedge clk) disable iff (rst)
    xbus_en |-> $past(prph_en));
endmodule

// File: tb/test_clkdiv_tree.sv
module test_clkdiv_tree;
  localparam int HALF = 10; // 20 ns period, 50 MHz
  localparam int NV = 7;
  // bus code, prph code, xbus code, bus gap, prph gap, xbus gap
  localparam int VEC [NV][6] = '{
    '{0, 0, 0, 1,  1,   1},
    '{1, 1, 1, 2,  4,   8},
    '{2, 2, 0, 3, 12,  12},
    '{0, 3, 3, 1,  8,  64},
    '{2, 3, 3, 3, 24, 192},
    '{3, 1, 2, 3,  6,  24},
    '{1, 2, 1, 2,  8,  16}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_bus_code = '0;
  logic [1:0] cfg_prph_code = '0;
  logic [1:0] cfg_xbus_code = '0;
  logic req_mem = 1'b0, req_prph = 1'b0, req_xbus = 1'b0;
  logic bus_en, irq_en, mem_en, mem_run, prph_en, prph_run, xbus_en, xbus_run;
  logic [31:0] tick_count;
  logic n_bus, n_irq, n_mem, n_mrun, n_prph, n_prun, n_xbus, n_xrun;
  logic [5:0] n_tick;

  int n_chk = 0;
  int n_err = 0;
  int cnt_mis = 0, n_mis = 0;
  int n_wraps = 0;
  logic [31:0] mdl = '0;
  logic [5:0] n_mdl = '0;

  always #HALF clk = ~clk;

  clkdiv_tree i_clkdiv_tree (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_bus_code(cfg_bus_code),
    .cfg_prph_code(cfg_prph_code), .cfg_xbus_code(cfg_xbus_code),
    .req_mem(req_mem), .req_prph(req_prph), .req_xbus(req_xbus),
    .bus_en(bus_en), .irq_en(irq_en), .mem_en(mem_en), .mem_run(mem_run),
    .prph_en(prph_en), .prph_run(prph_run), .xbus_en(xbus_en),
    .xbus_run(xbus_run), .tick_count(tick_count));

  clkdiv_tree #(.CNT_W(6)) i_clkdiv_tree_narrow (
    .clk(clk), .rst(rst), .cfg_wr(1'b0), .cfg_bus_code(2'd0),
    .cfg_prph_code(2'd0), .cfg_xbus_code(2'd0),
    .req_mem(1'b0), .req_prph(1'b0), .req_xbus(1'b0),
    .bus_en(n_bus), .irq_en(n_irq), .mem_en(n_mem), .mem_run(n_mrun),
    .prph_en(n_prph), .prph_run(n_prun), .xbus_en(n_xbus),
    .xbus_run(n_xrun), .tick_count(n_tick));

  // counter models, sampled midway between rising and falling edges
  always begin
    @(posedge clk);
    #5;
    if (rst) begin
      mdl = '0;
      n_mdl = '0;
    end else begin
      if (tick_count != mdl) cnt_mis++;
      if (n_tick != n_mdl) n_mis++;
      if (n_tick == 6'd0 && n_mdl == 6'd0 && n_irq == 1'b0 && n_bus == 1'b0) ;
      if (irq_en) mdl = mdl + 1;
      if (n_irq) begin
        if (n_mdl == 6'h3f) n_wraps++;
        n_mdl = n_mdl + 1'b1;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic pick(input int sel);
    case (sel)
      0: return bus_en;
      1: return irq_en;
      2: return mem_en;
      3: return prph_en;
      default: return xbus_en;
    endcase
  endfunction

  task automatic gap(input int sel, output int g);
    @(negedge clk);
    while (!pick(sel)) @(negedge clk);
    @(negedge clk);
    g = 1;
    while (!pick(sel)) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic write_cfg(input int b, input int p, input int x);
    @(negedge clk);
    cfg_bus_code  = 2'(b);
    cfg_prph_code = 2'(p);
    cfg_xbus_code = 2'(x);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int zero_state();
    return int'({bus_en, irq_en, mem_en, mem_run, prph_en, prph_run, xbus_en, xbus_run})
           + int'(tick_count != 0);
  endfunction

  initial begin
    #(2 * HALF * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int g;
    int cnt;
    int bad;
    req_mem = 1'b1;
    req_prph = 1'b1;
    req_xbus = 1'b1;
    idle(6);
    check("R2 outputs in reset", zero_state(), 0);
    rst = 1'b0;
    // R2 defaults: every ratio 2
    gap(0, g); check("R2 default bus gap", g, 2);
    gap(1, g); check("R3 default irq gap", g, 8);
    gap(2, g); check("R6 default mem gap", g, 2);
    gap(3, g); check("R2 default prph gap", g, 4);
    gap(4, g); check("R2 default xbus gap", g, 8);

    // table walk: R1 bus, R3 irq, R6 mem, R7 prph, R8 xbus
    for (int v = 0; v < NV; v++) begin
      write_cfg(VEC[v][0], VEC[v][1], VEC[v][2]);
      idle(450);
      gap(0, g); check("R1 bus gap", g, VEC[v][3]);
      gap(1, g); check("R3 irq gap", g, 4 * VEC[v][3]);
      gap(2, g); check("R6 mem gap", g, VEC[v][3]);
      gap(3, g); check("R7 prph gap", g, VEC[v][4]);
      gap(4, g); check("R8 xbus gap", g, VEC[v][5]);
    end

    // R11: ratio change keeps the current period
    req_xbus = 1'b0;
    write_cfg(0, 3, 0);
    idle(450);
    while (!prph_en) @(negedge clk);
    idle(2);
    cfg_prph_code = 2'd0;
    cfg_bus_code = 2'd0;
    cfg_xbus_code = 2'd0;
    cfg_wr = 1'b1;
    g = 2;
    do begin
      @(negedge clk);
      g++;
      if (g == 3) cfg_wr = 1'b0;
    end while (!prph_en);
    check("R11 old period kept", g, 8);
    @(negedge clk);
    check("R11 new ratio applied", int'(prph_en), 1);

    // R10: stop only after a full period
    write_cfg(0, 3, 0);
    idle(450);
    while (!prph_en) @(negedge clk);
    cnt = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == 3) req_prph = 1'b0;
      if (prph_en) cnt++;
      if (k == 7) check("R10 run held to period end", int'(prph_run), 1);
      if (k == 8) check("R10 run falls at period end", int'(prph_run), 0);
    end
    check("R10 no pulse after request drop", cnt, 0);

    // R9: start on the first parent pulse with the request high
    write_cfg(2, 3, 0);
    idle(50);
    cnt = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (prph_en || prph_run) cnt++;
    end
    check("R9 idle without request", cnt, 0);
    @(negedge clk);
    @(negedge clk);
    req_prph = 1'b1;
    bad = 0;
    while (!bus_en) begin
      if (prph_en) bad++;
      @(negedge clk);
    end
    check("R9 no pulse before parent", bad, 0);
    @(negedge clk);
    check("R9 first pulse after parent", int'(prph_en), 1);

    // R12: external request keeps the peripheral divider alive
    req_prph = 1'b0;
    req_xbus = 1'b1;
    idle(100);
    check("R12 prph running", int'(prph_run), 1);
    gap(4, g); check("R12 xbus gap", g, 24);

    // R6: memory gating
    req_mem = 1'b0;
    idle(20);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (mem_en || mem_run) cnt++;
    end
    check("R6 memory idle", cnt, 0);
    req_mem = 1'b1;
    idle(10);
    bad = 0;
    begin
      logic prev_bus;
      prev_bus = bus_en;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (mem_en != prev_bus) bad++;
        prev_bus = bus_en;
      end
    end
    check("R6 mem follows bus", bad, 0);

    // R2: reset in mid run restores defaults
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2 outputs in mid-run reset", zero_state(), 0);
    idle(3);
    rst = 1'b0;
    gap(0, g); check("R2 bus gap after reset", g, 2);
    gap(3, g); check("R2 prph gap after reset", g, 4);
    gap(4, g); check("R2 xbus gap after reset", g, 8);

    // R4 and R5: counter models
    idle(100);
    check("R4 tick count mismatches", cnt_mis, 0);
    check("R5 narrow count mismatches", n_mis, 0);
    check("R5 narrow count wrapped", int'(n_wraps > 0), 1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule